// File: doc/BRIEF.md
# Thermal Threshold Alert Controller

This block watches a 10-bit digital temperature code and compares it, every clock, against programmable limits. It keeps a shutdown flag with hysteresis. The flag sets when the reading climbs past a shutdown-hot limit and clears only once the reading drops below a shutdown-cold limit. The inverse of that flag is offered as an active-low warm-reset request, and the request is gated by an enable bit.

The shutdown limits normally come from fuse values that arrive on static inputs. Software can replace them with register values by writing one exact key into the override field. A second pair of limits drives two alert comparators, one for "too hot" and one for "cooled below". Each comparator has its own mask bit, and both feed one interrupt line. Software usually starts with the hot term unmasked. When the interrupt arrives, it masks the hot term and unmasks the cold term, so the same line later reports the cool-down.

A small word-addressed register port writes the control word and the two limit pairs. A combinational read port returns those registers and a status word that holds both the masked and the raw comparator results.

Top module: `thermal_guard`

## Requirements
- R1: After reset the hot mask is 0, the cold mask is 1, the override key is 0, the reset enable is 0 and the shutdown flag is 0. Reading the control word (address 0) returns 0x002, the alert interrupt is low and warm_rst_n is high.
- R2: The shutdown flag sets in the clock after a sample in which temp is strictly greater than the selected shutdown-hot limit. A reading equal to the limit does not set it.
- R3: The shutdown flag holds while the reading lies between the limits. It clears in the clock after a sample strictly below the selected shutdown-cold limit.
- R4: The selected shutdown limits are fuse_hot/fuse_cold unless the control key field (bits 6:4) equals 3'b111. In that case they are the register limits at address 1 (hot in bits 9:0, cold in bits 25:16). Any other key value selects the fuses.
- R5: warm_rst_n is low exactly when the shutdown flag is 1 and the reset-enable bit (control bit 2) is 1.
- R6: The raw hot comparator is 1 in the clock after a sample strictly above the alert-hot limit (address 2, bits 9:0). It drives the interrupt only while the hot mask (control bit 0) is 0.
- R7: The raw cold comparator is 1 in the clock after a sample strictly below the alert-cold limit (address 2, bits 25:16). It drives the interrupt only while the cold mask (control bit 1) is 0.
- R8: alert_irq is the OR of the two masked terms. Writing a mask bit to 1 removes that term from the cycle after the write.
- R9: The status word (address 3) holds the masked hot term in bit 0, the masked cold term in bit 1, raw hot in bit 4, raw cold in bit 5 and the shutdown flag in bit 8. All other bits read 0.
- R10: When the selected shutdown-hot limit is not above the shutdown-cold limit, a sample that meets both the set and the clear condition sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp | input | 10 | Temperature code, sampled every clock |
| fuse_hot | input | 10 | Fuse shutdown-hot limit |
| fuse_cold | input | 10 | Fuse shutdown-cold limit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| alert_irq | output | 1 | Combined masked alert interrupt |
| warm_rst_n | output | 1 | Gated active-low warm-reset request |

## Verification
Readings are placed just at and just beyond every limit. This separates strict from inclusive comparison on each of the four comparators. A rising sweep through the fuse limits, followed by a falling one, shows that the flag holds between the limits rather than tracking a single threshold. The same reading is then replayed under a near-miss key and under the exact key, which shows that the limit source really depends on the key. An inverted limit pair shows that setting wins over clearing. The hot-then-cold mask hand-off shows that one interrupt line reports both events.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
    localparam int TEMP_W   = 10;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int KEY_W    = 3;
    localparam int HI_LSB   = 16;
    localparam int KEY_LSB  = 4;
    localparam int MH_BIT   = 0;
    localparam int MC_BIT   = 1;
    localparam int EN_BIT   = 2;
    localparam int ST_SHUT  = 8;

    localparam logic [KEY_W-1:0]  OVR_KEY = '1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_SHUT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_ALERT = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

    typedef logic [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic             mask_hot;
        logic             mask_cold;
        logic             rst_en;
        logic [KEY_W-1:0] key;
        temp_t            sh_hot;
        temp_t            sh_cold;
        temp_t            al_hot;
        temp_t            al_cold;
    } cfg_t;

    typedef struct packed {
        logic raw_hot;
        logic raw_cold;
        logic shut;
    } sense_t;
endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import thermal_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;
    logic unused_wbits;

    assign unused_wbits = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    cfg_d.mask_hot  = wr_data[MH_BIT];
                    cfg_d.mask_cold = wr_data[MC_BIT];
                    cfg_d.rst_en    = wr_data[EN_BIT];
                    cfg_d.key       = wr_data[KEY_LSB +: KEY_W];
                end
                A_SHUT: begin
                    cfg_d.sh_hot  = wr_data[0 +: TEMP_W];
                    cfg_d.sh_cold = wr_data[HI_LSB +: TEMP_W];
                end
                A_ALERT: begin
                    cfg_d.al_hot  = wr_data[0 +: TEMP_W];
                    cfg_d.al_cold = wr_data[HI_LSB +: TEMP_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask_hot  <= 1'b0;
            cfg_q.mask_cold <= 1'b1;
            cfg_q.rst_en    <= 1'b0;
            cfg_q.key       <= '0;
            cfg_q.sh_hot    <= '1;
            cfg_q.sh_cold   <= '0;
            cfg_q.al_hot    <= '1;
            cfg_q.al_cold   <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/tg_limit_sel.sv
module tg_limit_sel
    import thermal_guard_pkg::*;
(
    input  cfg_t  cfg,
    input  temp_t fuse_hot,
    input  temp_t fuse_cold,
    output temp_t hot_sel,
    output temp_t cold_sel
);
    logic use_regs;

    always_comb begin
        use_regs = (cfg.key == OVR_KEY);
        hot_sel  = use_regs ? cfg.sh_hot  : fuse_hot;
        cold_sel = use_regs ? cfg.sh_cold : fuse_cold;
    end
endmodule

// File: rtl/tg_sense.sv
module tg_sense
    import thermal_guard_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  temp_t  temp,
    input  temp_t  hot_sel,
    input  temp_t  cold_sel,
    input  temp_t  al_hot,
    input  temp_t  al_cold,
    output sense_t sense
);
    sense_t sense_d, sense_q;

    always_comb begin
        sense_d          = sense_q;
        sense_d.raw_hot  = (temp > al_hot);
        sense_d.raw_cold = (temp < al_cold);
        if (temp > hot_sel) begin
            sense_d.shut = 1'b1;
        end else if (temp < cold_sel) begin
            sense_d.shut = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
        end else begin
            sense_q <= sense_d;
        end
    end

    assign sense = sense_q;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        temp,
    input  logic [9:0]        fuse_hot,
    input  logic [9:0]        fuse_cold,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              alert_irq,
    output logic              warm_rst_n
);
    cfg_t   cfg;
    sense_t sense;
    temp_t  shut_hot;
    temp_t  shut_cold;
    logic   hot_term;
    logic   cold_term;

    tg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    tg_limit_sel u_sel (
        .cfg       (cfg),
        .fuse_hot  (fuse_hot),
        .fuse_cold (fuse_cold),
        .hot_sel   (shut_hot),
        .cold_sel  (shut_cold)
    );

    tg_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .temp     (temp),
        .hot_sel  (shut_hot),
        .cold_sel (shut_cold),
        .al_hot   (cfg.al_hot),
        .al_cold  (cfg.al_cold),
        .sense    (sense)
    );

    always_comb begin
        hot_term   = sense.raw_hot  & ~cfg.mask_hot;
        cold_term  = sense.raw_cold & ~cfg.mask_cold;
        alert_irq  = hot_term | cold_term;
        warm_rst_n = ~(sense.shut & cfg.rst_en);
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[MH_BIT]             = cfg.mask_hot;
                rd_data[MC_BIT]             = cfg.mask_cold;
                rd_data[EN_BIT]             = cfg.rst_en;
                rd_data[KEY_LSB +: KEY_W]   = cfg.key;
            end
            A_SHUT: begin
                rd_data[0 +: TEMP_W]        = cfg.sh_hot;
                rd_data[HI_LSB +: TEMP_W]   = cfg.sh_cold;
            end
            A_ALERT: begin
                rd_data[0 +: TEMP_W]        = cfg.al_hot;
                rd_data[HI_LSB +: TEMP_W]   = cfg.al_cold;
            end
            default: begin
                rd_data[0]       = hot_term;
                rd_data[1]       = cold_term;
                rd_data[4]       = sense.raw_hot;
                rd_data[5]       = sense.raw_cold;
                rd_data[ST_SHUT] = sense.shut;
            end
        endcase
    end
endmodule

// File: rtl/tg_checker.sv
module tg_checker
    import thermal_guard_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input temp_t temp,
    input temp_t hot_sel,
    input temp_t cold_sel,
    input temp_t al_hot,
    input temp_t al_cold,
    input logic  mask_hot,
    input logic  mask_cold,
    input logic  rst_en,
    input logic  raw_hot,
    input logic  raw_cold,
    input logic  shut,
    input logic  alert_irq,
    input logic  warm_rst_n
);
    a_r2_set_above_hot: assert property (@(posedge clk) disable iff (!rst_n)
        (temp > hot_sel) |=> shut);

    a_r3_clear_below_cold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(temp > hot_sel) && (temp < cold_sel)) |=> !shut);

    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!(temp > hot_sel) && !(temp < cold_sel)) |=> $stable(shut));

    a_r5_gate_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_en |-> warm_rst_n);

    a_r6_raw_hot: assert property (@(posedge clk) disable iff (!rst_n)
        (temp > al_hot) |=> raw_hot);

    a_r7_raw_cold: assert property (@(posedge clk) disable iff (!rst_n)
        (temp < al_cold) |=> raw_cold);

    a_r8_hot_reaches_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_hot && !mask_hot) |-> alert_irq);

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_hot && mask_cold) |-> !alert_irq);
endmodule

bind thermal_guard tg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp       (temp),
    .hot_sel    (shut_hot),
    .cold_sel   (shut_cold),
    .al_hot     (cfg.al_hot),
    .al_cold    (cfg.al_cold),
    .mask_hot   (cfg.mask_hot),
    .mask_cold  (cfg.mask_cold),
    .rst_en     (cfg.rst_en),
    .raw_hot    (sense.raw_hot),
    .raw_cold   (sense.raw_cold),
    .shut       (sense.shut),
    .alert_irq  (alert_irq),
    .warm_rst_n (warm_rst_n)
);

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  temp = '0;
    logic [9:0]  fuse_hot = 10'd800;
    logic [9:0]  fuse_cold = 10'd700;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [31:0] rd_data;
    logic        alert_irq;
    logic        warm_rst_n;

    always #4 clk = ~clk;

    thermal_guard uut (
        .clk(clk), .rst_n(rst_n), .temp(temp), .fuse_hot(fuse_hot),
        .fuse_cold(fuse_cold), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .alert_irq(alert_irq), .warm_rst_n(warm_rst_n)
    );

    typedef struct {
        string       req;
        logic        irq;
        logic        rstn;
        logic [31:0] rd;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // requirement-level model state
    logic       m_mh = 1'b0, m_mc = 1'b1, m_en = 1'b0;
    logic [2:0] m_key = 3'd0;
    logic [9:0] m_sh = 10'h3ff, m_sc = 10'h0, m_ah = 10'h3ff, m_ac = 10'h0;
    logic       m_shut = 1'b0, m_rh = 1'b0, m_rc = 1'b0;

    task automatic tick(input logic [9:0] t);
        logic [9:0] hs, cs;
        hs = (m_key == 3'b111) ? m_sh : fuse_hot;
        cs = (m_key == 3'b111) ? m_sc : fuse_cold;
        if (t > hs)      m_shut = 1'b1;
        else if (t < cs) m_shut = 1'b0;
        m_rh = (t > m_ah);
        m_rc = (t < m_ac);
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            2'd0: begin v[0] = m_mh; v[1] = m_mc; v[2] = m_en; v[6:4] = m_key; end
            2'd1: begin v[9:0] = m_sh; v[25:16] = m_sc; end
            2'd2: begin v[9:0] = m_ah; v[25:16] = m_ac; end
            default: begin
                v[0] = m_rh & ~m_mh; v[1] = m_rc & ~m_mc;
                v[4] = m_rh; v[5] = m_rc; v[8] = m_shut;
            end
        endcase
        return v;
    endfunction

    // drive one sample and push the expected outputs after the next edge
    task automatic cyc(input string req, input logic [9:0] t, input logic [1:0] ra);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0;
        temp = t;
        rd_addr = ra;
        tick(t);
        it.req  = req;
        it.irq  = (m_rh & ~m_mh) | (m_rc & ~m_mc);
        it.rstn = ~(m_shut & m_en);
        it.rd   = exp_rd(ra);
        q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick(temp);
        case (a)
            2'd0: begin m_mh = d[0]; m_mc = d[1]; m_en = d[2]; m_key = d[6:4]; end
            2'd1: begin m_sh = d[9:0]; m_sc = d[25:16]; end
            2'd2: begin m_ah = d[9:0]; m_ac = d[25:16]; end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] ctl(input logic mh, input logic mc,
                                        input logic en, input logic [2:0] k);
        return {25'b0, k, 1'b0, en, mc, mh};
    endfunction

    function automatic logic [31:0] pair(input logic [9:0] hi, input logic [9:0] lo);
        return {6'b0, lo, 6'b0, hi};
    endfunction

    // monitor: compares results away from the clock edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                n_cmp++;
                if (alert_irq !== it.irq || warm_rst_n !== it.rstn || rd_data !== it.rd) begin
                    n_bad++;
                    $display("FAIL %s: got irq=%b rst_n=%b rd=%h, expected irq=%b rst_n=%b rd=%h",
                             it.req, alert_irq, warm_rst_n, rd_data, it.irq, it.rstn, it.rd);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc("R1 control after reset", 10'd0, 2'd0);
        cyc("R1 status after reset", 10'd0, 2'd3);
        // alert limits: hot 600, cold 300
        wr(2'd2, pair(10'd600, 10'd300));
        cyc("R6 equal to alert-hot does not trigger", 10'd600, 2'd3);
        cyc("R6 R8 R9 above alert-hot raises irq", 10'd601, 2'd3);
        wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 3'd0));
        cyc("R8 hot mask removes term", 10'd601, 2'd3);
        cyc("R7 equal to alert-cold does not trigger", 10'd300, 2'd3);
        cyc("R7 R9 below alert-cold raises irq", 10'd299, 2'd3);
        wr(2'd0, ctl(1'b1, 1'b1, 1'b0, 3'd0));
        cyc("R8 both masked keeps irq low", 10'd299, 2'd3);
        // shutdown on fuse limits 800 / 700
        cyc("R2 equal to fuse hot does not set", 10'd800, 2'd3);
        cyc("R2 R5 above fuse hot sets flag, reset gated", 10'd801, 2'd3);
        wr(2'd0, ctl(1'b1, 1'b1, 1'b1, 3'd0));
        cyc("R5 enable drives warm reset low", 10'd801, 2'd3);
        cyc("R3 hold between limits", 10'd750, 2'd3);
        cyc("R3 equal to fuse cold holds", 10'd700, 2'd3);
        cyc("R3 below fuse cold clears", 10'd699, 2'd3);
        // override key
        wr(2'd1, pair(10'd400, 10'd350));
        wr(2'd0, ctl(1'b1, 1'b1, 1'b1, 3'd6));
        cyc("R4 register limits readback", 10'd450, 2'd1);
        cyc("R4 near-miss key keeps fuse limits", 10'd450, 2'd3);
        wr(2'd0, ctl(1'b1, 1'b1, 1'b1, 3'd7));
        cyc("R4 exact key selects register limits", 10'd450, 2'd3);
        cyc("R4 hold with register limits", 10'd360, 2'd3);
        cyc("R4 clear below register cold", 10'd349, 2'd3);
        // inverted limits: set wins
        wr(2'd1, pair(10'd200, 10'd500));
        cyc("R10 set wins over clear", 10'd300, 2'd3);
        cyc("R10 above both stays set", 10'd600, 2'd3);
        cyc("R10 below both clears", 10'd100, 2'd3);
        wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 3'd0));
        cyc("R6 R7 unmasked readings in range", 10'd450, 2'd3);
        cyc("R1 control readback after clear", 10'd450, 2'd0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule